// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes a single asynchronous serial line and turns each frame into a byte held for software. Bit timing comes from an outside enable pulse, `os_tick`, that fires sixteen times per bit period. A falling edge on the idle-high line starts a frame. The start bit is confirmed at its centre. The data bits come in least significant first, and an optional parity bit and one or two stop bits follow. Each of these bits is sampled once at its centre.

When a frame completes, the block checks it. A good frame is stored and raises a data-full flag. A bad stop bit or a bad parity bit sets an error flag, and the byte is still stored. A frame that completes while the previous byte is still unclaimed sets an overrun flag, and the stored byte is kept. While any error flag is set, the receiver ignores the line. Software claims data and clears errors through one clear strobe per flag. Two interrupt outputs, one for received data and one for errors, share a single enable.

Top module: `async_rx_flags`

## Requirements
- R1: After reset, `rx_data`, `rx_full`, `err_ovr`, `err_frm`, `err_par`, `irq_end` and `irq_err` are all 0.
- R2: A frame starts on a high-to-low transition of `rxd`. The line is sampled again at the 8th `os_tick` after that transition. If the line is high there, the event is a glitch: no frame is received and no flag or data changes.
- R3: Data bits arrive least significant bit first. `cfg_seven`=0 selects 8 data bits. `cfg_seven`=1 selects 7 data bits, and then `rx_data[7]` reads 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0, the data bits plus the parity bit must contain an even number of ones. With `cfg_par_odd`=1, they must contain an odd number. A mismatch sets `err_par`, and the byte is still written to `rx_data`.
- R5: The first stop bit must be 1, or `err_frm` is set and the byte is still written to `rx_data`. With `cfg_two_stop`=1, the value of the second stop bit has no effect.
- R6: A frame with no error, arriving while `rx_full`=0, writes its byte to `rx_data` and sets `rx_full`.
- R7: A frame that completes while `rx_full`=1 sets `err_ovr`. In that case `rx_data` keeps its old value, `rx_full` stays 1, and `err_frm` and `err_par` are not changed.
- R8: While any of `err_ovr`, `err_frm` or `err_par` is 1, frames on `rxd` are ignored: `rx_data` and all flags stay unchanged until a clear strobe is given.
- R9: A frame that sets any error flag never sets `rx_full`.
- R10: Each flag drops in the cycle after its one-cycle clear strobe (`clr_full`, `clr_ovr`, `clr_frm`, `clr_par`). A clear wins over a set in the same cycle. Nothing else clears `rx_full`.
- R11: `irq_end` is 1 exactly when `rx_full`=1 and `int_en`=1. `irq_err` is 1 exactly when at least one error flag is 1 and `int_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle enable pulse, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits (only the first is checked) |
| int_en | input | 1 | Enable for both interrupt outputs |
| clr_full | input | 1 | Clear strobe for rx_full |
| clr_ovr | input | 1 | Clear strobe for err_ovr |
| clr_frm | input | 1 | Clear strobe for err_frm |
| clr_par | input | 1 | Clear strobe for err_par |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Received byte waiting |
| err_ovr | output | 1 | Overrun error |
| err_frm | output | 1 | Framing (stop bit) error |
| err_par | output | 1 | Parity error |
| irq_end | output | 1 | Receive-end interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The assertions check rules that can be judged one cycle at a time:
- a clear strobe always wins over a set;
- `rx_full` never rises together with, or while, an error flag is set;
- `rx_data` stays frozen while an error flag is held, and when an overrun is flagged;
- both interrupts stay low while `int_en` is low.

Only the bench's frame scenarios can show that the serial timing is right. That covers bit order, the 7-bit and 8-bit lengths, parity in both senses, glitch rejection, and that the second stop bit is ignored. These scenarios compare the byte and flags after each frame against a model of the error and blocking rules.

// File: rtl/async_rx_flags.sv
module async_rx_flags #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       cfg_seven,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       int_en,
  input  logic       clr_full,
  input  logic       clr_ovr,
  input  logic       clr_frm,
  input  logic       clr_par,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       err_ovr,
  output logic       err_frm,
  output logic       err_par,
  output logic       irq_end,
  output logic       irq_err
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP, STOP2} st_t;
  st_t st;

  logic [2:0] sync;
  logic [CW-1:0] cnt;
  logic [2:0] bidx;
  logic [7:0] shreg;
  logic pbit;
  logic rxs, fall, err_any, samp;
  logic [7:0] word;
  logic done, set_ovr, set_frm, set_par, set_full, load;

  assign rxs     = sync[1];
  assign fall    = sync[2] & ~sync[1];
  assign err_any = err_ovr | err_frm | err_par;
  assign samp    = os_tick && (cnt == LAST);
  assign word    = cfg_seven ? {1'b0, shreg[7:1]} : shreg;

  assign done     = (st == STOP) && samp;
  assign set_ovr  = done && rx_full;
  assign load     = done && !rx_full;
  assign set_frm  = load && !rxs;
  assign set_par  = load && cfg_par_en && ((^word) ^ pbit ^ cfg_par_odd);
  assign set_full = load && !set_frm && !set_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (fall && !err_any) begin
          st  <= START;
          cnt <= '0;
        end
        START: if (os_tick) begin
          if (cnt == MID) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxs ? IDLE : DATA;
          end else cnt <= cnt + 1'b1;
        end
        default: if (os_tick) cnt <= cnt + 1'b1;
      endcase
      if (samp) begin
        case (st)
          DATA: begin
            shreg <= {rxs, shreg[7:1]};
            bidx  <= bidx + 1'b1;
            if (bidx == (cfg_seven ? 3'd6 : 3'd7))
              st <= cfg_par_en ? PAR : STOP;
          end
          PAR:   begin pbit <= rxs; st <= STOP; end
          STOP:  st <= cfg_two_stop ? STOP2 : IDLE;
          STOP2: st <= IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      err_ovr <= 1'b0;
      err_frm <= 1'b0;
      err_par <= 1'b0;
    end else begin
      if (load) rx_data <= word;
      rx_full <= !clr_full && (rx_full || set_full);
      err_ovr <= !clr_ovr  && (err_ovr || set_ovr);
      err_frm <= !clr_frm  && (err_frm || set_frm);
      err_par <= !clr_par  && (err_par || set_par);
    end
  end

  assign irq_end = int_en & rx_full;
  assign irq_err = int_en & err_any;
endmodule

module async_rx_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_en,
  input logic       clr_full,
  input logic       clr_ovr,
  input logic       clr_frm,
  input logic       clr_par,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       err_ovr,
  input logic       err_frm,
  input logic       err_par,
  input logic       irq_end,
  input logic       irq_err
);
  logic any_err;
  assign any_err = err_ovr | err_frm | err_par;

  // R10
  clear_full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_full |=> !rx_full);
  // R10
  clear_err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && clr_frm && clr_par) |=> !any_err);
  // R9
  full_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !any_err && !$past(any_err));
  // R7
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> $stable(rx_data));
  // R8
  blocked_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && $past(any_err)) |-> $stable(rx_data));
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq_end && !irq_err);
endmodule

bind async_rx_flags async_rx_flags_chk u_chk (.*);

// File: tb/async_rx_flags_bench.sv
module async_rx_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK = 64;

  logic clk = 0, rst_n = 0, os_tick = 0, rxd = 1;
  logic cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, int_en = 0;
  logic clr_full = 0, clr_ovr = 0, clr_frm = 0, clr_par = 0;
  logic [7:0] rx_data;
  logic rx_full, err_ovr, err_frm, err_par, irq_end, irq_err;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_data = 0;
  logic m_full = 0, m_ovr = 0, m_frm = 0, m_par = 0;
  int tc = 0;

  async_rx_flags u_async_rx_flags (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tc = (tc + 1) % 4;
    os_tick = (tc == 0);
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bitx(logic v, int n = BITCLK);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mask(logic [7:0] d, logic sev);
    return sev ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic model(logic [7:0] d, logic badp, logic bads);
    if (m_ovr | m_frm | m_par) return;
    if (m_full) begin m_ovr = 1; return; end
    m_data = mask(d, cfg_seven);
    m_frm = bads;
    m_par = cfg_par_en & badp;
    m_full = !(m_frm | m_par);
  endtask

  task automatic frame(logic [7:0] d, logic badp, logic bads, logic s2);
    logic [7:0] w;
    w = mask(d, cfg_seven);
    bitx(0);
    for (int i = 0; i < (cfg_seven ? 7 : 8); i++) bitx(w[i]);
    if (cfg_par_en) bitx((^w) ^ cfg_par_odd ^ badp);
    bitx(~bads);
    if (cfg_two_stop) bitx(s2);
    bitx(1, 2 * BITCLK);
    model(d, badp, bads);
  endtask

  task automatic clear(logic f, logic o, logic r, logic p);
    clr_full = f; clr_ovr = o; clr_frm = r; clr_par = p;
    @(negedge clk);
    clr_full = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
    if (f) m_full = 0;
    if (o) m_ovr = 0;
    if (r) m_frm = 0;
    if (p) m_par = 0;
    @(negedge clk);
  endtask

  task automatic compare(string req);
    chk(req, rx_data, m_data);
    chk(req, {rx_full, err_ovr, err_frm, err_par}, {m_full, m_ovr, m_frm, m_par});
    chk({req, "/R11"}, {irq_end, irq_err},
        {int_en & m_full, int_en & (m_ovr | m_frm | m_par)});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    bitx(1, 2 * BITCLK);

    int_en = 1;
    frame(8'hA5, 0, 0, 1);
    compare("R6 R3 8bit");
    // R2: glitch shorter than half a bit is rejected
    bitx(0, 16); bitx(1, 2 * BITCLK);
    compare("R2 glitch");
    frame(8'h3C, 0, 0, 1);
    compare("R7 overrun");
    frame(8'h11, 0, 0, 1);
    compare("R8 blocked");
    clear(1, 1, 0, 0);
    compare("R10 clear");
    cfg_seven = 1; cfg_par_en = 1; cfg_par_odd = 1;
    frame(8'hFF, 0, 0, 1);
    compare("R3 7bit R4 odd");
    clear(1, 0, 0, 0);
    cfg_par_odd = 0;
    frame(8'h5A, 1, 0, 1);
    compare("R4 R9 parity err");
    clear(0, 0, 0, 1);
    cfg_seven = 0; cfg_par_en = 0; cfg_two_stop = 1;
    frame(8'hC3, 0, 0, 0);
    compare("R5 second stop ignored");
    clear(1, 0, 0, 0);
    frame(8'h96, 0, 1, 1);
    compare("R5 framing");
    clear(0, 0, 1, 0);
    int_en = 0;
    frame(8'h0F, 0, 0, 1);
    compare("R11 disabled");

    for (int k = 0; k < 120; k++) begin
      logic [7:0] d;
      logic bp, bs;
      d = 8'($urandom);
      bp = ($urandom % 8) == 0;
      bs = ($urandom % 8) == 0;
      cfg_seven = 1'($urandom); cfg_par_en = 1'($urandom);
      cfg_par_odd = 1'($urandom); cfg_two_stop = 1'($urandom);
      int_en = 1'($urandom);
      if (($urandom % 3) != 0)
        clear(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      frame(d, bp, bs, 1'($urandom));
      compare("R4 R5 R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule